// File: doc/BRIEF.md
# Two-Wire Bus Timeout Monitor

This block watches the clock and data lines of a two-wire bus and reports two timing conditions to the rest of a bus controller. The first is a clock-low timeout. A counter is reloaded while the clock line is high and advances once per system clock while the line is low. When it overflows, the block emits a one-cycle alarm that the controller uses to reset its bus logic.

The second condition is bus-free detection. Ticks from an external clock-source divider are counted while both lines stay high. Once more than a set number of ticks have passed, the bus is declared free. If a master START is waiting at that moment, a one-cycle start-permitted strobe is issued together with the free flag. Bus-free detection depends on the tick strobe, so the divider must keep running even in a slave-only setup.

Both raw line inputs pass through two-flop synchronizers before either detector sees them. The shift engine, arbitration and register access live elsewhere.

Top module: `bus_timeout_monitor`

## Requirements
- R1: During and after synchronous active-low reset, `low_timeout`, `bus_free` and `start_go` are 0, and both counters are cleared.
- R2: While the synchronized clock line is high, the low counter is held at its reload value. Two clock-low stretches of LOW_CYCLES-1 cycles each, separated by a high level, produce no alarm.
- R3: When the enable is set, a clock-line fall driven just after an edge gives a first `low_timeout` high on the (LOW_CYCLES+2)-th following rising edge. That is two synchronizer stages plus LOW_CYCLES counted low cycles.
- R4: `low_timeout` is high for exactly one cycle. It does not fire again until the clock line has been high, however long the line stays low.
- R5: With `low_to_en` at 0, `low_timeout` stays 0 for any length of clock-low time.
- R6: With `free_to_en` at 1 and both lines high, `bus_free` stays 0 after FREE_TICKS ticks. It becomes 1 on the rising edge that samples tick number FREE_TICKS+1.
- R7: Ticks sampled while either synchronized line is low are not counted. A low level on either line, even for one cycle, restarts the tick count from zero.
- R8: `bus_free` returns to 0 on the third rising edge after either raw line falls: two synchronizer stages plus one register.
- R9: With `free_to_en` at 0, `bus_free` and `start_go` stay 0 no matter how many ticks arrive.
- R10: `start_go` is a one-cycle strobe. It is raised on the same edge that sets `bus_free`, and only if `start_req` is 1 on that edge. With `start_req` at 0 on that edge, no strobe is issued during that free period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_raw | input | 1 | Asynchronous bus clock line |
| sda_raw | input | 1 | Asynchronous bus data line |
| tick | input | 1 | One-cycle strobe from the clock-source divider |
| low_to_en | input | 1 | Enables clock-low timeout detection |
| free_to_en | input | 1 | Enables bus-free detection |
| start_req | input | 1 | A master START is pending |
| low_timeout | output | 1 | One-cycle clock-low timeout alarm |
| bus_free | output | 1 | Bus has been idle for more than FREE_TICKS ticks |
| start_go | output | 1 | One-cycle permission to issue the pending START |

## Verification
The bench measures the exact edge on which the alarm first appears. A counter with an off-by-one reload, or a missing synchronizer stage, shows up as an early or late pulse. It holds the clock line low for several timeout periods to catch a detector that re-arms without seeing a high level, and it splits a low period into two short stretches to catch a counter that is not reloaded. On the free side, it checks the tick count on both sides of the threshold, injects a one-cycle data glitch and ticks during clock-low time to catch a counter that is not cleared, and checks the drop latency of the free flag for each line. It also checks `start_go` with and without a pending request, so a strobe that lasts too long or ignores the request is reported.

// File: rtl/bto_pkg.sv
// Package: shared defaults and the synchronized line pair type for the
// bus timeout monitor. Assumes nothing beyond IEEE 1800-2017.
package bto_pkg;

    // Default number of synchronized clock-low cycles before the alarm.
    localparam int unsigned DEF_LOW_CYCLES = 24;
    // Default low counter width; 2**width must exceed the low cycle count.
    localparam int unsigned DEF_LOW_CNT_W  = 6;
    // Default free threshold: bus is free after more than this many ticks.
    localparam int unsigned DEF_FREE_TICKS = 10;
    // Default synchronizer depth.
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Synchronized view of the two bus lines.
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

endpackage

// File: rtl/bto_sync.sv
// Module: multi-bit flop-chain synchronizer.
// Each bit passes through STAGES flops independently. Inputs are assumed
// to be level signals that change slowly relative to clk. On reset every
// stage loads RST_VAL (an idle bus reads high).
module bto_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Shift one raw bit through its own flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[b] <= {STAGES{RST_VAL}};
            end else begin
                chain[b] <= {chain[b][STAGES-2:0], d_async[b]};
            end
        end
        assign q_sync[b] = chain[b][STAGES-1];
    end

endmodule

// File: rtl/bto_low_timer.sv
// Module: clock-low timeout counter.
// Counts system clocks while the synchronized clock line is low, starting
// from a reload value chosen so that overflow happens after LOW_CYCLES low
// cycles. Overflow raises a one-cycle alarm, reloads, and disarms the
// detector until the line has been seen high again.
// Assumes scl_s is already synchronized to clk.
module bto_low_timer #(
    parameter int unsigned LOW_CNT_W  = 6,
    parameter int unsigned LOW_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_s,
    output logic alarm
);

    localparam logic [LOW_CNT_W-1:0] RELOAD =
        LOW_CNT_W'((1 << LOW_CNT_W) - LOW_CYCLES);
    localparam logic [LOW_CNT_W-1:0] TOP = '1;

    logic [LOW_CNT_W-1:0] cnt;
    logic                 armed;

    // Reload on high or disable, count on low, fire once on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= RELOAD;
            armed <= 1'b1;
            alarm <= 1'b0;
        end else begin
            alarm <= 1'b0;
            if (scl_s) begin
                cnt   <= RELOAD;
                armed <= 1'b1;
            end else if (!en) begin
                cnt <= RELOAD;
            end else if (armed) begin
                if (cnt == TOP) begin
                    cnt   <= RELOAD;
                    armed <= 1'b0;
                    alarm <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: a high clock line leaves the counter at its reload value.
    a_r2_reload_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        scl_s |=> (cnt == RELOAD));

    // R4: the alarm never lasts more than one cycle.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> !alarm);

    // R5: a disabled detector stays quiet.
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !alarm);

    // R4: an alarm is only possible while the line is still low.
    a_r4_alarm_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> $past(!scl_s));

endmodule

// File: rtl/bto_free_timer.sv
// Module: bus-free detector.
// Counts clock-source ticks while both lines are high. The tick that
// exceeds FREE_TICKS sets the free flag, and on that same edge grants a
// pending START with a one-cycle strobe. Any low level or a disable
// clears the count and the flag. Assumes idle and tick are synchronous to clk.
module bto_free_timer #(
    parameter int unsigned FREE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic idle,
    input  logic tick,
    input  logic start_req,
    output logic free,
    output logic go
);

    localparam int unsigned         FW   = $clog2(FREE_TICKS + 1);
    localparam logic [FW-1:0]       LAST = FW'(FREE_TICKS);

    logic [FW-1:0] cnt;

    // Count idle ticks; set the free flag on the one past the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            free <= 1'b0;
            go   <= 1'b0;
        end else begin
            go <= 1'b0;
            if (!en || !idle) begin
                cnt  <= '0;
                free <= 1'b0;
            end else if (tick && !free) begin
                if (cnt == LAST) begin
                    free <= 1'b1;
                    go   <= start_req;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R8: a low line drops the free flag on the next edge.
    a_r8_drop_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> !free);

    // R6: the flag only rises on an edge that sampled a tick.
    a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(free) |-> $past(tick));

    // R10: the START grant coincides with the flag rising.
    a_r10_go_with_free: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> $rose(free));

    // R10: the START grant lasts one cycle.
    a_r10_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

endmodule

// File: rtl/bus_timeout_monitor.sv
// Module: top of the two-wire bus timeout monitor.
// Synchronizes the raw clock and data lines, then feeds the clock-low
// timeout counter and the bus-free detector. Assumes tick is a one-cycle
// strobe synchronous to clk, and that all control inputs are synchronous.
module bus_timeout_monitor
    import bto_pkg::*;
#(
    parameter int unsigned LOW_CNT_W   = DEF_LOW_CNT_W,
    parameter int unsigned LOW_CYCLES  = DEF_LOW_CYCLES,
    parameter int unsigned FREE_TICKS  = DEF_FREE_TICKS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    input  logic tick,
    input  logic low_to_en,
    input  logic free_to_en,
    input  logic start_req,
    output logic low_timeout,
    output logic bus_free,
    output logic start_go
);

    bus_lines_t lines_s;
    logic       idle;

    // Bring both raw lines into the clk domain.
    bto_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({scl_raw, sda_raw}),
        .q_sync  (lines_s)
    );

    // Both lines high means the bus is idle.
    assign idle = lines_s.scl & lines_s.sda;

    bto_low_timer #(
        .LOW_CNT_W  (LOW_CNT_W),
        .LOW_CYCLES (LOW_CYCLES)
    ) u_low (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (low_to_en),
        .scl_s (lines_s.scl),
        .alarm (low_timeout)
    );

    bto_free_timer #(
        .FREE_TICKS (FREE_TICKS)
    ) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (free_to_en),
        .idle      (idle),
        .tick      (tick),
        .start_req (start_req),
        .free      (bus_free),
        .go        (start_go)
    );

    // R9: a disabled free detector reports nothing.
    a_r9_free_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !free_to_en |=> (!bus_free && !start_go));

    // R1: no output is asserted in the cycle after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!low_timeout && !bus_free && !start_go));

endmodule

// File: tb/bus_timeout_monitor_tb.sv
module bus_timeout_monitor_tb;

    localparam int N  = 24;
    localparam int FT = 10;

    logic clk = 1'b0;
    logic rst_n, scl_raw, sda_raw, tick, low_to_en, free_to_en, start_req;
    logic low_timeout, bus_free, start_go;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    always #2 clk = ~clk;

    bus_timeout_monitor #(.LOW_CNT_W(6), .LOW_CYCLES(N), .FREE_TICKS(FT)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .tick(tick), .low_to_en(low_to_en), .free_to_en(free_to_en),
        .start_req(start_req), .low_timeout(low_timeout),
        .bus_free(bus_free), .start_go(start_go)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic lines_idle();
        scl_raw = 1'b1;
        sda_raw = 1'b1;
        cyc(4);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(3);
        check(!low_timeout && !bus_free && !start_go, "R1 outputs in reset",
              {low_timeout, bus_free, start_go}, 0);
        rst_n = 1'b1;
        cyc(1);
        check(!low_timeout && !bus_free && !start_go, "R1 outputs after reset",
              {low_timeout, bus_free, start_go}, 0);
    endtask

    task automatic t_low_exact();
        int first = -1;
        int extra = 0;
        lines_idle();
        scl_raw = 1'b0;
        for (int k = 1; k <= N + 4; k++) begin
            @(negedge clk);
            if (low_timeout && first < 0) first = k;
        end
        check(first == N + 2, "R3 alarm edge", first, N + 2);
        for (int k = 0; k < 3 * N; k++) begin
            @(negedge clk);
            if (low_timeout) extra++;
        end
        check(extra == 0, "R4 no refire while low", extra, 0);
        lines_idle();
    endtask

    task automatic t_low_width();
        int width = 0;
        scl_raw = 1'b0;
        for (int k = 0; k < N + 6; k++) begin
            @(negedge clk);
            if (low_timeout) width++;
        end
        check(width == 1, "R4 pulse width", width, 1);
        lines_idle();
    endtask

    task automatic t_low_reload();
        int cnt = 0;
        scl_raw = 1'b0;
        for (int k = 0; k < N - 1; k++) begin
            @(negedge clk);
            if (low_timeout) cnt++;
        end
        scl_raw = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (low_timeout) cnt++;
        end
        scl_raw = 1'b0;
        for (int k = 0; k < N - 1; k++) begin
            @(negedge clk);
            if (low_timeout) cnt++;
        end
        scl_raw = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (low_timeout) cnt++;
        end
        check(cnt == 0, "R2 reload on high", cnt, 0);
    endtask

    task automatic t_low_disabled();
        int cnt = 0;
        low_to_en = 1'b0;
        scl_raw = 1'b0;
        for (int k = 0; k < 3 * N; k++) begin
            @(negedge clk);
            if (low_timeout) cnt++;
        end
        check(cnt == 0, "R5 disabled no alarm", cnt, 0);
        lines_idle();
        low_to_en = 1'b1;
    endtask

    task automatic t_free_threshold();
        lines_idle();
        pulse_tick(FT);
        check(!bus_free, "R6 not free after FREE_TICKS", bus_free, 0);
        pulse_tick(1);
        check(bus_free, "R6 free after FREE_TICKS+1", bus_free, 1);
        check(!start_go, "R10 no grant without request", start_go, 0);
    endtask

    task automatic t_free_drop(input bit on_scl);
        if (on_scl) scl_raw = 1'b0; else sda_raw = 1'b0;
        cyc(2);
        check(bus_free, on_scl ? "R8 free held 2 edges (scl)" : "R8 free held 2 edges (sda)", bus_free, 1);
        cyc(1);
        check(!bus_free, on_scl ? "R8 free drops on scl" : "R8 free drops on sda", bus_free, 0);
        lines_idle();
    endtask

    task automatic t_free_restart();
        lines_idle();
        pulse_tick(6);
        sda_raw = 1'b0;
        cyc(1);
        sda_raw = 1'b1;
        cyc(4);
        pulse_tick(FT);
        check(!bus_free, "R7 glitch restarts count", bus_free, 0);
        pulse_tick(1);
        check(bus_free, "R7 free after restart", bus_free, 1);
        scl_raw = 1'b0;
        cyc(4);
        pulse_tick(FT + 3);
        check(!bus_free, "R7 ticks during low ignored", bus_free, 0);
        scl_raw = 1'b1;
        cyc(4);
        pulse_tick(FT);
        check(!bus_free, "R7 count starts at zero after low", bus_free, 0);
        pulse_tick(1);
        check(bus_free, "R7 free after full count", bus_free, 1);
    endtask

    task automatic t_free_disabled();
        free_to_en = 1'b0;
        start_req = 1'b1;
        lines_idle();
        pulse_tick(3 * FT);
        check(!bus_free && !start_go, "R9 disabled never free",
              {bus_free, start_go}, 0);
        start_req = 1'b0;
        free_to_en = 1'b1;
    endtask

    task automatic t_start_grant();
        sda_raw = 1'b0;
        cyc(2);
        lines_idle();
        start_req = 1'b1;
        pulse_tick(FT);
        check(!start_go, "R10 no grant before free", start_go, 0);
        pulse_tick(1);
        check(start_go && bus_free, "R10 grant with free", {start_go, bus_free}, 3);
        cyc(1);
        check(!start_go && bus_free, "R10 grant one cycle", {start_go, bus_free}, 1);
        pulse_tick(3);
        check(!start_go, "R10 no second grant", start_go, 0);
        start_req = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; scl_raw = 1'b1; sda_raw = 1'b1; tick = 1'b0;
        low_to_en = 1'b1; free_to_en = 1'b1; start_req = 1'b0;
        t_reset();
        t_low_exact();
        t_low_width();
        t_low_reload();
        t_low_disabled();
        t_free_threshold();
        t_free_drop(1'b1);
        t_free_threshold();
        t_free_drop(1'b0);
        t_free_restart();
        t_free_disabled();
        t_start_grant();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule